// File: doc/BRIEF.md
# Per-Bit Decision Forest Evaluator

This block turns a word of binary input features into an n-bit prediction word, one bit at a time. Every output bit has its own small ensemble of decision trees. Because the features are single bits, an internal tree node only has to say which feature bit it tests: a 0 sends the walk to the left child and a 1 sends it to the right child. Each leaf holds an 8-bit probability that the output bit is 1. For each output bit, the forest adds the leaf probabilities its trees reach. It drives a 1 only when the class-1 share is strictly larger than the class-0 share.

Evaluation is purely combinational, built as a cascade of selectors from the root of each tree down to a leaf. The tree contents sit in registers. They are loaded one entry at a time through a small write port that is qualified by a configuration enable. Typical use is to load the forests once and then present a new feature word every cycle, taking the prediction word as the input to the next stage.

Top module: `bitforest_eval`

## Requirements
- R1: After reset every node select and every leaf value is 0, so `pred_out` reads all zeros for any feature word.
- R2: A configuration write takes place only at a rising clock edge where both `cfg_en` and `cfg_wr` are 1. When either one is 0, the edge changes no stored value, and therefore no later prediction.
- R3: `cfg_addr` is laid out as {forest[FW], tree[TW], kind[1], slot[DEPTH]}, with the forest field in the most significant bits. Kind 0 writes the feature index of internal node `slot`, taken from the low bits of `cfg_wdata`. Kind 1 writes the 8-bit value of leaf `slot`. A write is dropped if it names a forest at or above OUT_BITS, a tree at or above N_TREES, or internal slot 2^DEPTH-1.
- R4: Each tree walk starts at node 0. Node i tests `feat_in[sel_i]` and moves to node 2i+1 on a 0 or to node 2i+2 on a 1. After DEPTH tests the walk reaches leaf number (node − (2^DEPTH − 1)).
- R5: Output bit f is 1 exactly when the sum of the leaf values reached in forest f is greater than N_TREES×128. A leaf value v stands for a class-1 probability of v/256. A sum equal to N_TREES×128 is a tie and gives 0.
- R6: Bit f of `pred_out` depends only on forest f. Writes addressed to one forest leave the other output bits unchanged.
- R7: `pred_out` follows `feat_in` within the same cycle, with no clock edge in between. A configuration write is reflected in `pred_out` right after the edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Active-low synchronous reset, clears all tree contents |
| cfg_en | input | 1 | Configuration enable; writes are ignored while low |
| cfg_wr | input | 1 | Write strobe |
| cfg_addr | input | FW+TW+1+DEPTH (10) | Write address {forest, tree, kind, slot} |
| cfg_wdata | input | 8 | Node feature index (low bits) or leaf probability |
| feat_in | input | IN_BITS (16) | Binary input feature word |
| pred_out | output | OUT_BITS (4) | Concatenated per-bit forest predictions |

## Verification
The bench loads random forests and compares every output bit with a reference tree walk. A design that mirrors the child rule, or that mixes up leaf numbering, fails on most random feature words. Directed cases target three boundaries. The first sets every leaf to 128 to produce an exact tie; a design that uses greater-or-equal would output 1 there. The second issues writes with only one of the two enables high; a design that gates on the strobe alone would let probability 255 leak into a forest that should read 0. The third aims writes at the unused internal slot and the missing tree index; a design that wraps these addresses would corrupt a live tree, and the random comparisons that follow would expose it.

// File: rtl/bfe_pkg.sv
package bfe_pkg;
    localparam int PROB_W = 8;
    localparam int HALF_PROB = 128;

    typedef enum logic {
        KIND_NODE = 1'b0,
        KIND_LEAF = 1'b1
    } cfg_kind_e;
endpackage

// File: rtl/bfe_tree.sv
module bfe_tree
    import bfe_pkg::*;
#(
    parameter int IN_BITS = 16,
    parameter int DEPTH   = 5,
    parameter int FW      = 2,
    parameter int TW      = 2,
    parameter int FID     = 0,
    parameter int TID     = 0,
    localparam int ADDR_W = FW + TW + 1 + DEPTH
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_en,
    input  logic               cfg_wr,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [PROB_W-1:0]  cfg_wdata,
    input  logic [IN_BITS-1:0] feat_in,
    output logic [PROB_W-1:0]  leaf_p
);
    localparam int SELW  = (IN_BITS > 1) ? $clog2(IN_BITS) : 1;
    localparam int NNODE = (1 << DEPTH) - 1;
    localparam int NLEAF = 1 << DEPTH;
    localparam logic [FW-1:0]    MY_F     = FW'(FID);
    localparam logic [TW-1:0]    MY_T     = TW'(TID);
    localparam logic [DEPTH-1:0] DEAD_SLT = DEPTH'(NNODE);

    logic [NNODE*SELW-1:0]   sel_q;
    logic [NLEAF*PROB_W-1:0] leaf_q;

    logic [FW-1:0]    a_forest;
    logic [TW-1:0]    a_tree;
    cfg_kind_e        a_kind;
    logic [DEPTH-1:0] a_slot;
    logic             hit;

    assign a_forest = cfg_addr[ADDR_W-1 -: FW];
    assign a_tree   = cfg_addr[ADDR_W-FW-1 -: TW];
    assign a_kind   = cfg_kind_e'(cfg_addr[DEPTH]);
    assign a_slot   = cfg_addr[DEPTH-1:0];
    assign hit      = cfg_en && cfg_wr && (a_forest == MY_F) && (a_tree == MY_T);

    // configuration storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            leaf_q <= '0;
        end else if (hit) begin
            unique case (a_kind)
                KIND_LEAF: leaf_q[a_slot*PROB_W +: PROB_W] <= cfg_wdata;
                KIND_NODE: if (a_slot != DEAD_SLT)
                               sel_q[a_slot*SELW +: SELW] <= cfg_wdata[SELW-1:0];
                default: ;
            endcase
        end
    end

    // root-to-leaf selector cascade
    logic [DEPTH-1:0] leaf_idx;
    always_comb begin
        int unsigned nd;
        logic [SELW-1:0] s;
        logic b;
        nd = 0;
        for (int lvl = 0; lvl < DEPTH; lvl++) begin
            s = sel_q[nd*SELW +: SELW];
            b = (int'(s) < IN_BITS) ? feat_in[s] : 1'b0;
            nd = 2 * nd + 1 + int'(b);
        end
        leaf_idx = DEPTH'(nd - NNODE);
    end

    assign leaf_p = leaf_q[leaf_idx*PROB_W +: PROB_W];

    AST_GATED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_en && cfg_wr) |=> ($stable(leaf_q) && $stable(sel_q))); // R2

    AST_LEAF_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && a_kind == KIND_LEAF) |=>
            (leaf_q[$past(a_slot)*PROB_W +: PROB_W] == $past(cfg_wdata))); // R3

    AST_ROOT_STEER: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(sel_q[SELW-1:0]) < IN_BITS) |->
            (leaf_idx[DEPTH-1] == feat_in[sel_q[SELW-1:0]])); // R4
endmodule

// File: rtl/bfe_forest.sv
module bfe_forest
    import bfe_pkg::*;
#(
    parameter int IN_BITS = 16,
    parameter int DEPTH   = 5,
    parameter int N_TREES = 3,
    parameter int FW      = 2,
    parameter int TW      = 2,
    parameter int FID     = 0,
    localparam int ADDR_W = FW + TW + 1 + DEPTH
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_en,
    input  logic               cfg_wr,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [PROB_W-1:0]  cfg_wdata,
    input  logic [IN_BITS-1:0] feat_in,
    output logic               pred_bit
);
    localparam int SUMW = PROB_W + $clog2(N_TREES + 1);
    localparam logic [SUMW-1:0] THRESH = SUMW'(N_TREES * HALF_PROB);

    logic [N_TREES-1:0][PROB_W-1:0] probs;

    for (genvar t = 0; t < N_TREES; t++) begin : g_tree
        bfe_tree #(
            .IN_BITS(IN_BITS), .DEPTH(DEPTH), .FW(FW), .TW(TW),
            .FID(FID), .TID(t)
        ) i_tree (
            .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_wr(cfg_wr),
            .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
            .feat_in(feat_in), .leaf_p(probs[t])
        );
    end

    logic [SUMW-1:0] sum;
    always_comb begin
        sum = '0;
        for (int t = 0; t < N_TREES; t++) sum = sum + SUMW'(probs[t]);
    end

    // strict majority: tie resolves to class 0
    assign pred_bit = (sum > THRESH);

    logic all_hi, all_lo;
    always_comb begin
        all_hi = 1'b1;
        all_lo = 1'b1;
        for (int t = 0; t < N_TREES; t++) begin
            if (probs[t] <= PROB_W'(HALF_PROB)) all_hi = 1'b0;
            if (probs[t] >  PROB_W'(HALF_PROB)) all_lo = 1'b0;
        end
    end

    AST_UNANIMOUS_HI: assert property (@(posedge clk) disable iff (!rst_n)
        all_hi |-> pred_bit); // R5

    AST_UNANIMOUS_LO: assert property (@(posedge clk) disable iff (!rst_n)
        all_lo |-> !pred_bit); // R5
endmodule

// File: rtl/bitforest_eval.sv
module bitforest_eval
    import bfe_pkg::*;
#(
    parameter int IN_BITS  = 16,
    parameter int OUT_BITS = 4,
    parameter int N_TREES  = 3,
    parameter int DEPTH    = 5,
    localparam int FW      = (OUT_BITS > 1) ? $clog2(OUT_BITS) : 1,
    localparam int TW      = (N_TREES > 1) ? $clog2(N_TREES) : 1,
    localparam int ADDR_W  = FW + TW + 1 + DEPTH
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_en,
    input  logic                cfg_wr,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [PROB_W-1:0]   cfg_wdata,
    input  logic [IN_BITS-1:0]  feat_in,
    output logic [OUT_BITS-1:0] pred_out
);
    for (genvar f = 0; f < OUT_BITS; f++) begin : g_forest
        bfe_forest #(
            .IN_BITS(IN_BITS), .DEPTH(DEPTH), .N_TREES(N_TREES),
            .FW(FW), .TW(TW), .FID(f)
        ) i_forest (
            .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_wr(cfg_wr),
            .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
            .feat_in(feat_in), .pred_bit(pred_out[f])
        );
    end
endmodule

// File: tb/test_bitforest_eval.sv
module test_bitforest_eval;
    localparam int IN_BITS  = 16;
    localparam int OUT_BITS = 4;
    localparam int N_TREES  = 3;
    localparam int DEPTH    = 5;
    localparam int NNODE    = 31;
    localparam int NLEAF    = 32;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic                rst_n;
    logic                cfg_en, cfg_wr;
    logic [9:0]          cfg_addr;
    logic [7:0]          cfg_wdata;
    logic [IN_BITS-1:0]  feat_in;
    logic [OUT_BITS-1:0] pred_out;

    bitforest_eval #(.IN_BITS(IN_BITS), .OUT_BITS(OUT_BITS),
                     .N_TREES(N_TREES), .DEPTH(DEPTH)) i_bitforest_eval (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_wr(cfg_wr),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .feat_in(feat_in), .pred_out(pred_out)
    );

    int sel_m  [OUT_BITS][N_TREES][NNODE];
    int leaf_m [OUT_BITS][N_TREES][NLEAF];
    int checks = 0;
    int errors = 0;

    function automatic logic [OUT_BITS-1:0] model(logic [IN_BITS-1:0] x);
        logic [OUT_BITS-1:0] r;
        for (int f = 0; f < OUT_BITS; f++) begin
            int sum = 0;
            for (int t = 0; t < N_TREES; t++) begin
                int nd = 0;
                for (int l = 0; l < DEPTH; l++)
                    nd = 2 * nd + 1 + int'(x[sel_m[f][t][nd]]);
                sum += leaf_m[f][t][nd - NNODE];
            end
            r[f] = (sum > N_TREES * 128);
        end
        return r;
    endfunction

    task automatic chk(string req, logic [OUT_BITS-1:0] act, logic [OUT_BITS-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic wr(bit en, bit w, int f, int t, int k, int s, int d);
        @(negedge clk);
        cfg_en    = en;
        cfg_wr    = w;
        cfg_addr  = {2'(f), 2'(t), 1'(k), 5'(s)};
        cfg_wdata = 8'(d);
        @(posedge clk);
        #1;
        cfg_en = 1'b0;
        cfg_wr = 1'b0;
        if (en && w && f < OUT_BITS && t < N_TREES) begin
            if (k == 1) leaf_m[f][t][s] = d & 255;
            else if (s < NNODE) sel_m[f][t][s] = d % IN_BITS;
        end
    endtask

    task automatic probe(logic [IN_BITS-1:0] x, string req);
        @(negedge clk);
        feat_in = x;
        #2;
        chk(req, pred_out, model(x));
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        foreach (sel_m[f, t, n]) sel_m[f][t][n] = 0;
        foreach (leaf_m[f, t, n]) leaf_m[f][t][n] = 0;
        rst_n = 1'b0; cfg_en = 1'b0; cfg_wr = 1'b0;
        cfg_addr = '0; cfg_wdata = '0; feat_in = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: cleared after reset
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            feat_in = 16'($urandom);
            #2 chk("R1 reset zero", pred_out, '0);
        end

        // R3: full random load, then R4 R5 R6 random walks
        for (int f = 0; f < OUT_BITS; f++)
            for (int t = 0; t < N_TREES; t++) begin
                for (int n = 0; n < NNODE; n++) wr(1, 1, f, t, 0, n, $urandom % 256);
                for (int n = 0; n < NLEAF; n++) wr(1, 1, f, t, 1, n, $urandom % 256);
            end
        for (int i = 0; i < 150; i++) probe(16'($urandom), "R3 R4 R5 R6 random");

        // R7: combinational response without any clock edge
        for (int i = 0; i < 6; i++) begin
            logic [IN_BITS-1:0] x;
            @(negedge clk);
            feat_in = 16'($urandom);
            #1 x = 16'($urandom);
            feat_in = x;
            #1 chk("R7 same-cycle", pred_out, model(x));
        end

        // R3: dropped addresses (unused slot, missing tree)
        for (int f = 0; f < OUT_BITS; f++) begin
            wr(1, 1, f, 0, 0, NNODE, $urandom % 256);
            wr(1, 1, f, 3, 1, $urandom % NLEAF, $urandom % 256);
            wr(1, 1, f, 3, 0, $urandom % NNODE, $urandom % 256);
        end
        for (int i = 0; i < 30; i++) probe(16'($urandom), "R3 dropped write");

        // R2 R6: forest 0 leaves to 0, then gated writes of 255
        for (int t = 0; t < N_TREES; t++)
            for (int n = 0; n < NLEAF; n++) wr(1, 1, 0, t, 1, n, 0);
        for (int i = 0; i < 8; i++) probe(16'($urandom), "R6 forest0 cleared");
        for (int t = 0; t < N_TREES; t++)
            for (int n = 0; n < NLEAF; n++) begin
                wr(0, 1, 0, t, 1, n, 255);
                wr(1, 0, 0, t, 1, n, 255);
            end
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            feat_in = 16'($urandom);
            #2 chk("R2 gated write", {3'b000, pred_out[0]}, 4'b0000);
        end

        // R5: exact tie gives 0, one step above gives 1
        for (int t = 0; t < N_TREES; t++)
            for (int n = 0; n < NLEAF; n++) wr(1, 1, 0, t, 1, n, 128);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            feat_in = 16'($urandom);
            #2 chk("R5 tie", {3'b000, pred_out[0]}, 4'b0000);
        end
        wr(1, 1, 0, 1, 1, 0, 129);
        for (int n = 1; n < NLEAF; n++) wr(1, 1, 0, 1, 1, n, 129);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            feat_in = 16'($urandom);
            #2 chk("R5 above tie", {3'b000, pred_out[0]}, 4'b0001);
        end
        for (int i = 0; i < 10; i++) probe(16'($urandom), "R5 R6 mixed");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule